// File: doc/BRIEF.md
# Recursive Crosswise 8x8 Unsigned Multiplier

This block multiplies two 8-bit unsigned operands into a 16-bit product. It builds the product bottom-up. A gate-level 2x2 cell is the leaf. Four such cells and a small padded adder network form a 4x4 tile. Four 4x4 tiles, one per pair of operand nibbles, feed a two-level adder network made of one 8-bit adder and two 12-bit adders. Every adder is an explicit ripple chain. No behavioural `*` is used in the datapath.

The low product nibble comes straight from the low-by-low tile with no addition. The upper twelve bits come from the padded adder tree.

An optional output register, selected by a parameter, adds one cycle of latency. It also carries a valid flag that a synchronous active-low reset clears. With the register removed, the product and the valid flag pass through combinationally.

Top module: `xw_mult8`

## Requirements
- R1: For every pair of 8-bit unsigned operands `in_a`, `in_b`, the product presented with a valid output equals `in_a * in_b` as a 16-bit unsigned value.
- R2: Product bits [3:0] equal bits [3:0] of `in_a[3:0] * in_b[3:0]`.
- R3: No adder in the product network carries out of its width for any operand pair; this includes the all-ones operands, which give the largest intermediate sums.
- R4: With `OUT_REG=1`, `out_valid` and `out_prod` reflect `in_valid` and the operands exactly one clock edge later.
- R5: While `rst_n` is low at a clock edge, `out_valid` is 0 after that edge. The reset is synchronous and active low.
- R6: With `OUT_REG=1`, a cycle with `in_valid` low leaves `out_prod` unchanged and drops `out_valid` to 0.
- R7: A zero operand on either side yields a zero product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands are valid this cycle |
| in_a | input | 8 | Unsigned multiplicand |
| in_b | input | 8 | Unsigned multiplier |
| out_valid | output | 1 | Product is valid |
| out_prod | output | 16 | Unsigned 16-bit product |

## Verification
The hardest case to reach is a carry that crosses both adder levels. Such a carry starts in the low-by-low tile and must ripple through the 8-bit adder and then the final 12-bit adder. Only certain nibble combinations with large cross terms trigger it.

Random stimulus reaches it only by chance. The bench therefore sweeps all 65536 operand pairs back to back with `in_valid` held high, so every carry path is exercised. After the sweep, a seeded random phase with gaps in `in_valid` checks the hold behaviour of the output register. Directed all-ones and zero operands then cover the extremes.

// File: rtl/xw_pkg.sv
// Package: shared widths and types for the recursive crosswise multiplier.
// Assumes unsigned operands; the operand width is fixed at 8 by the
// four-tile structure, and every other width is derived from it.
package xw_pkg;
    localparam int unsigned OPW    = 8;
    localparam int unsigned HALFW  = OPW / 2;
    localparam int unsigned QUARTW = HALFW / 2;
    localparam int unsigned PRODW  = 2 * OPW;
    localparam int unsigned TILEW  = 2 * HALFW;
    localparam int unsigned MIDW   = TILEW + HALFW;

    typedef logic [OPW-1:0]   opnd_t;
    typedef logic [PRODW-1:0] prod_t;
    typedef logic [TILEW-1:0] tile_t;
endpackage

// File: rtl/xw_add.sv
// Module: W-bit ripple-carry adder built from a generate chain of full adders.
// Assumes no carry-in; the carry-out is exposed so callers can prove it unused.
module xw_add #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] s,
    output logic         co
);
    logic [W:0] c;

    assign c[0] = 1'b0;

    // One full adder per bit position, rippling the carry upward.
    for (genvar i = 0; i < W; i++) begin : g_fa
        assign s[i]   = x[i] ^ y[i] ^ c[i];
        assign c[i+1] = (x[i] & y[i]) | (c[i] & (x[i] ^ y[i]));
    end

    assign co = c[W];
endmodule

// File: rtl/xw_leaf2.sv
// Module: 2x2 unsigned leaf multiplier in plain gates.
// Assumes unsigned inputs; the 4-bit result holds the largest value, 9.
module xw_leaf2 (
    input  logic [1:0] a,
    input  logic [1:0] b,
    output logic [3:0] p
);
    logic cross_lo, cross_hi, cross_k, top;

    // Vertical and crosswise partial products with half-adder merging.
    always_comb begin
        cross_lo = a[1] & b[0];
        cross_hi = a[0] & b[1];
        cross_k  = cross_lo & cross_hi;
        top      = a[1] & b[1];
        p[0]     = a[0] & b[0];
        p[1]     = cross_lo ^ cross_hi;
        p[2]     = top ^ cross_k;
        p[3]     = top & cross_k;
    end
endmodule

// File: rtl/xw_tile4.sv
// Module: 4x4 unsigned multiplier made of four 2x2 leaves and a padded adder
// network with the same shape as the 8x8 level, one level down.
// Assumes unsigned inputs; ovf reports any adder carry-out (never set).
module xw_tile4 (
    input  logic [3:0] a,
    input  logic [3:0] b,
    output logic [7:0] p,
    output logic       ovf
);
    logic [3:0] pp [4];
    logic [3:0] s_lo;
    logic [5:0] s_hi, s_fin;
    logic       co_lo, co_hi, co_fin;

    // Leaf k multiplies the a half k[0] by the b half k[1].
    for (genvar k = 0; k < 4; k++) begin : g_leaf
        xw_leaf2 u_leaf (
            .a (a[2*(k%2) +: 2]),
            .b (b[2*(k/2) +: 2]),
            .p (pp[k])
        );
    end

    xw_add #(.W(4)) u_add_lo (
        .x ({2'b00, pp[0][3:2]}), .y (pp[1]), .s (s_lo), .co (co_lo)
    );
    xw_add #(.W(6)) u_add_hi (
        .x ({2'b00, pp[2]}), .y ({pp[3], 2'b00}), .s (s_hi), .co (co_hi)
    );
    xw_add #(.W(6)) u_add_fin (
        .x ({2'b00, s_lo}), .y (s_hi), .s (s_fin), .co (co_fin)
    );

    // Assemble the tile product and gather the unused carries.
    always_comb begin
        p   = {s_fin, pp[0][1:0]};
        ovf = co_lo | co_hi | co_fin;
    end
endmodule

// File: rtl/xw_mult8.sv
// Module: 8x8 unsigned multiplier from four 4x4 tiles plus one 8-bit and two
// 12-bit adders, with an optional output register (OUT_REG).
// Assumes a synchronous active-low reset and unsigned operands.
module xw_mult8
    import xw_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [7:0]  in_a,
    input  logic [7:0]  in_b,
    output logic        out_valid,
    output logic [15:0] out_prod
);
    tile_t           q [4];
    logic [3:0]      tile_ovf;
    logic [TILEW-1:0] q4;
    logic [MIDW-1:0]  q5, q6;
    logic            co4, co5, co6;
    prod_t           prod_c;

    // Tile k multiplies operand nibble k[0] of a by nibble k[1] of b.
    for (genvar k = 0; k < 4; k++) begin : g_tile
        xw_tile4 u_tile (
            .a   (in_a[HALFW*(k%2) +: HALFW]),
            .b   (in_b[HALFW*(k/2) +: HALFW]),
            .p   (q[k]),
            .ovf (tile_ovf[k])
        );
    end

    xw_add #(.W(TILEW)) u_add_q4 (
        .x ({{HALFW{1'b0}}, q[0][TILEW-1:HALFW]}), .y (q[1]), .s (q4), .co (co4)
    );
    xw_add #(.W(MIDW)) u_add_q5 (
        .x ({{HALFW{1'b0}}, q[2]}), .y ({q[3], {HALFW{1'b0}}}), .s (q5), .co (co5)
    );
    xw_add #(.W(MIDW)) u_add_q6 (
        .x ({{HALFW{1'b0}}, q4}), .y (q5), .s (q6), .co (co6)
    );

    // Final product: tree sum above the untouched low nibble of q0.
    always_comb prod_c = {q6, q[0][HALFW-1:0]};

    if (OUT_REG) begin : g_reg
        // Valid flag register with synchronous active-low clear.
        always_ff @(posedge clk) begin
            if (!rst_n) out_valid <= 1'b0;
            else        out_valid <= in_valid;
        end

        // Product register loads only on valid input and holds otherwise.
        always_ff @(posedge clk) begin
            if (in_valid) out_prod <= prod_c;
        end

        // R4
        valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (out_valid == $past(in_valid)));
        // R1
        prod_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (out_prod == ({8'b0, $past(in_a)} * {8'b0, $past(in_b)})));
        // R6
        prod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && !$past(in_valid) |-> $stable(out_prod));
        // R5
        rst_clr_chk: assert property (@(posedge clk)
            $past(!rst_n) |-> !out_valid);
    end else begin : g_comb
        // Combinational pass-through when no output register is wanted.
        always_comb begin
            out_valid = in_valid;
            out_prod  = prod_c;
        end
    end

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> !(co4 | co5 | co6 | (|tile_ovf)));
    // R2
    low_nib_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (prod_c[3:0] == q[0][3:0]));
endmodule

// File: tb/xw_mult8_tb_top.sv
`timescale 1ns/1ps
module xw_mult8_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_a = '0;
    logic [7:0]  in_b = '0;
    logic        out_valid;
    logic [15:0] out_prod;

    int unsigned n_run = 0;
    int unsigned n_fail = 0;
    logic        done = 1'b0;

    always #10 clk = ~clk;

    xw_mult8 #(.OUT_REG(1'b1)) dut_i (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid),
        .in_a (in_a), .in_b (in_b),
        .out_valid (out_valid), .out_prod (out_prod)
    );

    function automatic logic [15:0] ref_prod(input logic [7:0] a, input logic [7:0] b);
        return 16'(a) * 16'(b);
    endfunction

    function automatic logic [3:0] ref_low(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] t;
        t = 8'(a[3:0]) * 8'(b[3:0]);
        return t[3:0];
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Apply one operand pair at a negedge; the product appears after the next posedge.
    task automatic drive(input logic v, input logic [7:0] a, input logic [7:0] b);
        @(negedge clk);
        in_valid = v; in_a = a; in_b = b;
    endtask

    initial begin
        logic [7:0]  pa, pb;
        logic [15:0] held;
        void'($urandom(32'd1357));

        // R5: reset with a valid input pending still clears out_valid.
        in_valid = 1'b1;
        repeat (3) @(negedge clk);
        chk("R5", 16'(out_valid), 16'd0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R5", 16'(out_valid), 16'd0);

        // R1 R2 R4: exhaustive back-to-back sweep, checked one cycle later.
        drive(1'b1, 8'd0, 8'd0);
        pa = 8'd0; pb = 8'd0;
        for (int i = 1; i <= 65536; i++) begin
            @(negedge clk);
            chk("R4", 16'(out_valid), 16'd1);
            chk("R1", out_prod, ref_prod(pa, pb));
            chk("R2", 16'(out_prod[3:0]), 16'(ref_low(pa, pb)));
            if (i < 65536) begin
                pa = 8'(i % 256); pb = 8'(i / 256);
                in_a = pa; in_b = pb; in_valid = 1'b1;
            end
        end
        in_valid = 1'b0;
        @(negedge clk);

        // R6 R4: random operands with random gaps in in_valid.
        held = out_prod;
        for (int k = 0; k < 4000; k++) begin
            logic v;
            v  = 1'($urandom % 2);
            pa = 8'($urandom); pb = 8'($urandom);
            in_valid = v; in_a = pa; in_b = pb;
            @(negedge clk);
            chk("R4", 16'(out_valid), 16'(v));
            if (v) begin
                chk("R1", out_prod, ref_prod(pa, pb));
                held = ref_prod(pa, pb);
            end else begin
                chk("R6", out_prod, held);
            end
        end

        // R3: all-ones operands give the largest sums in every adder.
        drive(1'b1, 8'hFF, 8'hFF);
        @(negedge clk);
        chk("R3", out_prod, 16'hFE01);
        // R6: idle cycle with new operands leaves the product untouched.
        in_valid = 1'b0; in_a = 8'h12; in_b = 8'h34;
        @(negedge clk);
        chk("R6", out_prod, 16'hFE01);
        chk("R6", 16'(out_valid), 16'd0);

        // R7: zero on either side.
        drive(1'b1, 8'h00, 8'hC7);
        @(negedge clk);
        chk("R7", out_prod, 16'd0);
        drive(1'b1, 8'h9B, 8'h00);
        @(negedge clk);
        chk("R7", out_prod, 16'd0);
        // R2: low nibble from the low-by-low term only (0xF * 0xF = 0xE1).
        drive(1'b1, 8'h0F, 8'hAF);
        @(negedge clk);
        chk("R2", 16'(out_prod[3:0]), 16'h1);
        in_valid = 1'b0;

        // R5: mid-run reset clears the valid flag.
        drive(1'b1, 8'h55, 8'h66);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R5", 16'(out_valid), 16'd0);
        rst_n = 1'b1; in_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule